// File: doc/BRIEF.md
# Impedance calibration sequencer

This block is the digital controller of an on-die driver impedance calibration engine. A start pulse begins a calibration run with two phases. The pull-up phase always comes first and the pull-down phase second. In each phase the sequencer drives a trial code to the analog replica leg and a select bit that names the phase. It then reads a one-bit comparator result that reports where the pad node sits relative to the half-supply reference. Three comparator samples are taken for each decision and a 2-of-3 vote decides. A settle cycle comes before each group of three samples.

A long run performs a full successive-approximation search, most significant bit first, for each 5-bit code. A short run is a tracking update: it moves each code by at most one LSB toward the match point and saturates at 0 and 31. While a run is in progress the codes that feed the driver and termination legs stay unchanged. At the end of the pull-down phase both new codes are written on the same clock edge. A single-cycle done pulse marks that update.

Top module: `imp_cal_seq`

## Requirements
- R1: While reset is asserted, and after it is released, both published codes equal 16 (5'b10000), busy is low and done is low.
- R2: A long run (long_i = 1 when start is accepted) leaves each published code equal to the largest code for which the filtered comparator reads 1. cmp_i = 1 means the trial code is at or below the match point. A comparator that always reads 1 gives 31, and one that always reads 0 gives 0.
- R3: Within a run, trial_pd_o is 0 for the whole pull-up phase and 1 for the whole pull-down phase. It never returns from 1 to 0 while busy.
- R4: Each decision uses three comparator samples taken on consecutive cycles after a settle cycle, and follows the majority value. A single inverted sample among the three does not change the result.
- R5: A short run (long_i = 0 when start is accepted) changes each code by at most one: +1 if the code is below the match point, −1 if above, unchanged if equal. The code saturates at 0 and 31.
- R6: The published codes hold their values while a run is in progress. Both are written together, on the same edge on which done rises.
- R7: busy rises on the edge after an accepted start. done is high for exactly one cycle, and busy is low in that cycle.
- R8: A start pulse that arrives while busy is ignored. Neither the mode, the result nor the duration of the running calibration changes.
- R9: A run finishes within its cycle budget. The budget is 512 cycles for the first long run after reset, 256 cycles for later long runs and 64 cycles for a short run.
- R10: In a long run, the first trial code of the pull-up phase is 16 (only the MSB set), and it appears on the edge after start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration request, acted on only while idle |
| long_i | input | 1 | Run type sampled with start: 1 full search, 0 one-step tracking |
| cmp_i | input | 1 | Comparator result: 1 when the trial code is at or below the match point |
| trial_code_o | output | 5 | Trial code driven to the replica leg (0 while idle) |
| trial_pd_o | output | 1 | Phase select: 0 pull-up replica, 1 pull-down replica |
| pu_code_o | output | 5 | Published pull-up code for the driver and termination legs |
| pd_code_o | output | 5 | Published pull-down code for the driver and termination legs |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when new codes are published |

## Verification
The assertions assume that reset is held across at least one rising edge. They also assume that long_i matters only in the cycle in which start is accepted. They place no constraint on cmp_i, so the phase-order, hold, pulse and budget properties must hold for any comparator behaviour. The bench drives every input on the falling edge and models the comparator as a threshold on the trial code for the phase currently selected. The injected comparator noise flips at most one cycle in any four, which keeps every three-sample window within what a 2-of-3 vote can correct.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } cal_state_e;

  typedef enum logic {
    STEP_UP = 1'b0,
    STEP_DN = 1'b1
  } trim_step_e;

  // True when more than half of the samples voted one.
  function automatic logic majority(input int ones, input int total);
    return (ones * 2) > total;
  endfunction

  // Cycle allowance for a run of the given kind.
  function automatic int budget_cycles(input logic long_run, input logic first_run,
                                       input int init_lim, input int oper_lim,
                                       input int short_lim);
    if (!long_run) return short_lim;
    return first_run ? init_lim : oper_lim;
  endfunction

endpackage

// File: rtl/imp_cal_vote.sv
module imp_cal_vote
  import imp_cal_pkg::*;
#(
  parameter int VOTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_i,
  input  logic cmp_i,
  output logic decide_o,
  output logic vote_o
);
  localparam int HIST_W = VOTES - 1;
  localparam int CNT_W  = $clog2(VOTES + 1);

  logic [HIST_W-1:0] hist;
  logic [CNT_W-1:0]  cnt;
  logic [VOTES-1:0]  window;

  assign window   = {hist, cmp_i};
  assign vote_o   = majority($countones(window), VOTES);
  assign decide_o = smp_i && (cnt == CNT_W'(VOTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (smp_i) begin
      hist <= window[HIST_W-1:0];
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/imp_cal_sar.sv
module imp_cal_sar
  import imp_cal_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              long_i,
  input  logic [CODE_W-1:0] seed_i,
  input  logic              decide_i,
  input  logic              vote_i,
  output logic [CODE_W-1:0] trial_o,
  output logic              fin_o,
  output logic [CODE_W-1:0] res_o
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0]  MSB_IDX  = IDX_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  function automatic logic [CODE_W-1:0] step_up(input logic [CODE_W-1:0] c);
    return (c == CODE_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] step_down(input logic [CODE_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic [CODE_W-1:0] work, work_n, bit_mask;
  logic [IDX_W-1:0]  bit_idx;
  trim_step_e        step;
  logic              fin;

  assign bit_mask = CODE_W'(1) << bit_idx;
  assign trial_o  = long_i ? (work | bit_mask)
                           : ((step == STEP_UP) ? step_up(work) : work);

  always_comb begin
    work_n = work;
    fin    = 1'b0;
    if (decide_i) begin
      if (long_i) begin
        if (vote_i) work_n = work | bit_mask;
        fin = (bit_idx == '0);
      end else if (step == STEP_UP) begin
        if (vote_i) begin
          work_n = step_up(work);
          fin    = 1'b1;
        end
      end else begin
        fin = 1'b1;
        if (!vote_i) work_n = step_down(work);
      end
    end
  end

  assign fin_o = fin;
  assign res_o = work_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work    <= '0;
      bit_idx <= MSB_IDX;
      step    <= STEP_UP;
    end else if (load_i) begin
      work    <= long_i ? '0 : seed_i;
      bit_idx <= MSB_IDX;
      step    <= (!long_i && seed_i == CODE_MAX) ? STEP_DN : STEP_UP;
    end else if (decide_i) begin
      work <= work_n;
      if (long_i && bit_idx != '0) bit_idx <= bit_idx - 1'b1;
      if (!long_i && step == STEP_UP && !vote_i) step <= STEP_DN;
    end
  end
endmodule

// File: rtl/imp_cal_hold.sv
module imp_cal_hold #(
  parameter int CODE_W   = 5,
  parameter int RST_CODE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pu_fin_i,
  input  logic              pd_fin_i,
  input  logic [CODE_W-1:0] res_i,
  output logic [CODE_W-1:0] pu_code_o,
  output logic [CODE_W-1:0] pd_code_o
);
  localparam logic [CODE_W-1:0] INIT = CODE_W'(RST_CODE);

  logic [CODE_W-1:0] pu_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_stage  <= INIT;
      pu_code_o <= INIT;
      pd_code_o <= INIT;
    end else begin
      if (pu_fin_i) pu_stage <= res_i;
      if (pd_fin_i) begin
        pu_code_o <= pu_stage;
        pd_code_o <= res_i;
      end
    end
  end
endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
  import imp_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_i,
  input  logic decide_i,
  input  logic fin_i,
  output logic settle_o,
  output logic smp_o,
  output logic load_o,
  output logic load_pd_o,
  output logic long_sel_o,
  output logic run_long_o,
  output logic phase_o,
  output logic pu_fin_o,
  output logic pd_fin_o,
  output logic busy_o,
  output logic done_o,
  output logic first_o
);
  cal_state_e state;
  logic       phase, run_long, calibrated, accept;

  assign accept     = (state == ST_IDLE) && start_i;
  assign settle_o   = (state == ST_SETTLE);
  assign smp_o      = (state == ST_SAMPLE);
  assign pu_fin_o   = smp_o && decide_i && fin_i && !phase;
  assign pd_fin_o   = smp_o && decide_i && fin_i && phase;
  assign load_o     = accept || pu_fin_o;
  assign load_pd_o  = smp_o;
  assign long_sel_o = (state == ST_IDLE) ? mode_i : run_long;
  assign run_long_o = run_long;
  assign phase_o    = phase;
  assign busy_o     = (state != ST_IDLE);
  assign first_o    = !calibrated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      run_long   <= 1'b0;
      calibrated <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= pd_fin_o;
      if (pd_fin_o) calibrated <= 1'b1;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state    <= ST_SETTLE;
          phase    <= 1'b0;
          run_long <= mode_i;
        end
        ST_SETTLE: state <= ST_SAMPLE;
        ST_SAMPLE: if (decide_i) begin
          if (pd_fin_o) begin
            state <= ST_IDLE;
            phase <= 1'b0;
          end else begin
            state <= ST_SETTLE;
            if (pu_fin_o) phase <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imp_cal_seq.sv
module imp_cal_seq #(
  parameter int CODE_W        = 5,
  parameter int VOTES         = 3,
  parameter int RST_CODE      = 16,
  parameter int LONG_INIT_CYC = 512,
  parameter int LONG_OPER_CYC = 256,
  parameter int SHORT_CYC     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              long_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_code_o,
  output logic              trial_pd_o,
  output logic [CODE_W-1:0] pu_code_o,
  output logic [CODE_W-1:0] pd_code_o,
  output logic              busy_o,
  output logic              done_o
);
  logic settle, smp, load, load_pd, long_sel, run_long, phase;
  logic pu_fin, pd_fin, first_run, decide, vote, fin;
  logic [CODE_W-1:0] seed, trial, res;

  imp_cal_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (long_i),
    .decide_i  (decide),
    .fin_i     (fin),
    .settle_o  (settle),
    .smp_o     (smp),
    .load_o    (load),
    .load_pd_o (load_pd),
    .long_sel_o(long_sel),
    .run_long_o(run_long),
    .phase_o   (phase),
    .pu_fin_o  (pu_fin),
    .pd_fin_o  (pd_fin),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .first_o   (first_run)
  );

  imp_cal_vote #(.VOTES(VOTES)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (settle),
    .smp_i   (smp),
    .cmp_i   (cmp_i),
    .decide_o(decide),
    .vote_o  (vote)
  );

  assign seed = load_pd ? pd_code_o : pu_code_o;

  imp_cal_sar #(.CODE_W(CODE_W)) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .long_i  (long_sel),
    .seed_i  (seed),
    .decide_i(decide),
    .vote_i  (vote),
    .trial_o (trial),
    .fin_o   (fin),
    .res_o   (res)
  );

  imp_cal_hold #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .pu_fin_i (pu_fin),
    .pd_fin_i (pd_fin),
    .res_i    (res),
    .pu_code_o(pu_code_o),
    .pd_code_o(pd_code_o)
  );

  assign trial_code_o = busy_o ? trial : '0;
  assign trial_pd_o   = phase;
endmodule

// File: rtl/imp_cal_seq_chk.sv
module imp_cal_seq_chk
  import imp_cal_pkg::*;
#(
  parameter int CODE_W        = 5,
  parameter int LONG_INIT_CYC = 512,
  parameter int LONG_OPER_CYC = 256,
  parameter int SHORT_CYC     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              trial_pd_o,
  input logic [CODE_W-1:0] pu_code_o,
  input logic [CODE_W-1:0] pd_code_o,
  input logic              run_long,
  input logic              first_run
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (!busy_o) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && $past(trial_pd_o) |-> trial_pd_o); // R3

  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pu_code_o) && $stable(pd_code_o)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o)); // R7

  AST_SHORT_STEP_PU: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !run_long |-> (pu_code_o == $past(pu_code_o)) ||
                            (pu_code_o == $past(pu_code_o) + 1'b1) ||
                            (pu_code_o == $past(pu_code_o) - 1'b1)); // R5

  AST_SHORT_STEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !run_long |-> (pd_code_o == $past(pd_code_o)) ||
                            (pd_code_o == $past(pd_code_o) + 1'b1) ||
                            (pd_code_o == $past(pd_code_o) - 1'b1)); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(run_long)); // R8

  AST_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> 32'(busy_cnt) < budget_cycles(run_long, first_run, LONG_INIT_CYC,
                                             LONG_OPER_CYC, SHORT_CYC)); // R9
endmodule

bind imp_cal_seq imp_cal_seq_chk #(
  .CODE_W       (CODE_W),
  .LONG_INIT_CYC(LONG_INIT_CYC),
  .LONG_OPER_CYC(LONG_OPER_CYC),
  .SHORT_CYC    (SHORT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .trial_pd_o(trial_pd_o),
  .pu_code_o (pu_code_o),
  .pd_code_o (pd_code_o),
  .run_long  (run_long),
  .first_run (first_run)
);

// File: tb/imp_cal_seq_bench.sv
`timescale 1ns/1ps
module imp_cal_seq_bench;
  typedef struct packed {
    logic              lng;
    logic              noisy;
    logic signed [6:0] pu_t;
    logic signed [6:0] pd_t;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0,  7'sd20,  7'sd9},
    '{1'b0, 1'b0,  7'sd20,  7'sd9},
    '{1'b0, 1'b0,  7'sd25,  7'sd3},
    '{1'b0, 1'b1,  7'sd25,  7'sd3},
    '{1'b1, 1'b1,  7'sd5,   7'sd27},
    '{1'b1, 1'b0,  7'sd32, -7'sd1},
    '{1'b0, 1'b0,  7'sd32, -7'sd1},
    '{1'b1, 1'b0,  7'sd0,   7'sd31},
    '{1'b0, 1'b1, -7'sd1,   7'sd32},
    '{1'b1, 1'b1,  7'sd13,  7'sd18}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lng = 1'b0;
  logic cmp, trial_pd, busy, done;
  logic [4:0] trial, pu, pd;
  int   pu_tgt = 0, pd_tgt = 0;
  logic noise_en = 1'b0;
  logic [1:0] ncnt = 2'd0;

  int checks = 0, fails = 0;
  int exp_pu = 16, exp_pd = 16;
  bit first_run = 1'b1;
  int long_cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ncnt <= ncnt + 2'd1;

  assign cmp = ((trial_pd ? pd_tgt : pu_tgt) >= int'(trial)) ^ (noise_en && ncnt == 2'd3);

  imp_cal_seq u_imp_cal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .long_i(lng), .cmp_i(cmp),
    .trial_code_o(trial), .trial_pd_o(trial_pd), .pu_code_o(pu), .pd_code_o(pd),
    .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int clamp(input int t);
    return (t < 0) ? 0 : ((t > 31) ? 31 : t);
  endfunction

  function automatic int step_to(input int old, input int t);
    if (t > old && old < 31) return old + 1;
    if (t < old && old > 0) return old - 1;
    return old;
  endfunction

  task automatic run_cal(input bit l, input bit nz, input int put, input int pdt,
                         input bit poke, output int cyc);
    int new_pu, new_pd, lim;
    bit seen_pd, bad_order, hold_bad;
    string req;
    pu_tgt = put; pd_tgt = pdt; noise_en = nz;
    new_pu = l ? clamp(put) : step_to(exp_pu, put);
    new_pd = l ? clamp(pdt) : step_to(exp_pd, pdt);
    lim    = l ? (first_run ? 512 : 256) : 64;
    req    = nz ? "R4" : (l ? "R2" : "R5");
    @(negedge clk); start = 1'b1; lng = l;
    @(negedge clk); start = 1'b0;
    cyc = 1; seen_pd = 0; bad_order = 0; hold_bad = 0;
    check(busy === 1'b1, "R7", "busy after start", busy, 1);
    if (l) begin
      check(trial === 5'd16, "R10", "first trial code", trial, 16);
      check(trial_pd === 1'b0, "R3", "first phase", trial_pd, 0);
    end
    while (done !== 1'b1 && cyc < 1000) begin
      if (trial_pd) seen_pd = 1;
      else if (seen_pd) bad_order = 1;
      if (pu !== 5'(exp_pu) || pd !== 5'(exp_pd)) hold_bad = 1;
      if (poke && cyc == 5) begin start = 1'b1; lng = ~l; end
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    check(done === 1'b1, "R7", "done seen", done, 1);
    check(busy === 1'b0, "R7", "busy low with done", busy, 0);
    check(int'(pu) == new_pu, req, "pull-up code", pu, new_pu);
    check(int'(pd) == new_pd, req, "pull-down code", pd, new_pd);
    check(!hold_bad, "R6", "codes held while busy", hold_bad, 0);
    check(seen_pd && !bad_order, "R3", "phase order", bad_order, 0);
    check(cyc <= lim, "R9", "run length", cyc, lim);
    exp_pu = new_pu; exp_pd = new_pd; first_run = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R7", "done one cycle", done, 0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    repeat (2) @(negedge clk);
    check(pu === 5'd16 && pd === 5'd16, "R1", "codes in reset", pu, 16);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pu === 5'd16 && pd === 5'd16, "R1", "codes after reset", pd, 16);

    for (int i = 0; i < NV; i++) begin
      run_cal(VECS[i].lng, VECS[i].noisy, int'(VECS[i].pu_t), int'(VECS[i].pd_t), 1'b0, cyc);
      if (VECS[i].lng && !VECS[i].noisy) long_cycles = cyc;
    end

    // R8: a start pulse during a long run must not disturb it
    run_cal(1'b1, 1'b0, 7, 24, 1'b1, cyc);
    check(cyc == long_cycles, "R8", "duration with extra start", cyc, long_cycles);
    check(pu === 5'd7 && pd === 5'd24, "R8", "result with extra start", pu, 7);

    // R1: reset in the middle of a run restores the initial state
    @(negedge clk); start = 1'b1; lng = 1'b1; pu_tgt = 2; pd_tgt = 2;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pu === 5'd16 && pd === 5'd16, "R1", "codes after mid-run reset", pu, 16);
    check(busy === 1'b0 && done === 1'b0, "R1", "idle after mid-run reset", busy, 0);
    rst_n = 1'b1; exp_pu = 16; exp_pd = 16; first_run = 1'b1;
    @(negedge clk);

    // R9: first long run after reset uses the initial budget
    run_cal(1'b1, 1'b0, 30, 1, 1'b0, cyc);
    run_cal(1'b0, 1'b0, 0, 31, 1'b0, cyc);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule